// File: doc/BRIEF.md
# Word-Serial Montgomery Modular Multiplier

This block computes the Montgomery product R = A·B·2^(−W·L) mod N for operands of L words, each W bits wide. The caller first writes A, B, the modulus N and the precomputed reduction coefficient into internal word memories through a single word-wide write port. A start pulse then launches one multiplication. When done pulses, the L result words can be read back through a combinational read port.

Inside, three multiply-accumulate lanes run in lockstep over 2·L outer steps. The first lane builds A·B one low word per step. The second lane multiplies the low half of that product by the coefficient. The third lane multiplies the low half of the second lane's output by N. Each lane handles P multiplicand words per cycle, and every element keeps its own carry from one step to the next. A word-wide adder and subtractor consume the lowest word of the first and third lanes on every step, so a single pass yields both S = A·B + Q·N and S − N·2^(W·L). The final carry and borrow decide which of the two is the reduced result.

The block does not compute the coefficient or the domain-conversion factor, and it does not sequence exponents.

Top module: `mm_montmul`

## Requirements
- R1: With N odd, A < N, B < N and the coefficient equal to −N^(−1) mod 2^(W·L), the result equals A·B·2^(−W·L) mod N. Word 0 is the least significant word of every operand and of the result.
- R2: A write with wr_en high stores wr_data at word wr_addr of the memory chosen by wr_sel. The encoding is 0 for A, 1 for B, 2 for the coefficient and 3 for N.
- R3: Out of reset the block is idle, with busy and done low. A start sampled while idle makes busy high in the next cycle.
- R4: busy stays high for exactly 2·L·(L/P)+1 cycles. done is high for exactly one cycle, and that cycle is the first idle cycle after busy falls.
- R5: A start pulse that arrives while busy is high has no effect on either the result or the latency.
- R6: Each accepted start clears all accumulators, the per-element carries and the one-bit carry and borrow. A result therefore does not depend on earlier multiplications.
- R7: The result is fully reduced (strictly below N). This holds even when the intermediate sum overflows the 2·L-word range, for example with N = 2^(W·L)−1 and A = B = N−1.
- R8: rd_data combinationally shows result word rd_addr. That word stays unchanged while the block is idle, including across operand writes, until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Operand word write strobe |
| wr_sel | input | 2 | Operand memory select (0 A, 1 B, 2 coefficient, 3 N) |
| wr_addr | input | max(1,clog2(L)) | Word index of the write |
| wr_data | input | W | Operand word to store |
| start | input | 1 | Launch one multiplication (taken only when idle) |
| busy | output | 1 | High while a multiplication is in progress |
| done | output | 1 | One-cycle pulse when the result is readable |
| rd_addr | input | max(1,clog2(L)) | Result word index |
| rd_data | output | W | Result word at rd_addr |

## Verification
The bench builds the block with W=16, L=4 and P=2, so every operand is 64 bits. A bench model with 130-bit integers can then reduce results one bit at a time, independently of the word pipeline. With two chunks per outer step, the bench exercises the hand-off of the top accumulator from one chunk to the chunk below it, and it exercises the reuse of the registered lane multiplier words on non-first chunks. The short 17-cycle run leaves room for random odd moduli, the all-ones modulus that forces the overflow path, zero and unit operands, and a start pulse injected in the middle of a run.

// File: rtl/mm_pkg.sv
// Shared definitions for the Montgomery multiplier: controller states and
// operand memory selector codes used by the write port.
package mm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } mm_state_t;

    localparam logic [1:0] OP_A  = 2'd0;
    localparam logic [1:0] OP_B  = 2'd1;
    localparam logic [1:0] OP_NC = 2'd2;
    localparam logic [1:0] OP_N  = 2'd3;

endpackage

// File: rtl/mm_pe.sv
// Processing element: returns the low and high words of a*b + t + c.
// Assumes all four inputs are W-bit unsigned; the full sum always fits 2W bits.
module mm_pe #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] t,
    input  logic [W-1:0] c,
    output logic [W-1:0] sum,
    output logic [W-1:0] carry
);
    logic [2*W-1:0] full;

    // Multiply-accumulate in double width
    always_comb begin
        full  = (2*W)'(a) * (2*W)'(b) + (2*W)'(t) + (2*W)'(c);
        sum   = full[W-1:0];
        carry = full[2*W-1:W];
    end
endmodule

// File: rtl/mm_mac_lane.sv
// One multiply-accumulate lane: L accumulator/carry word pairs and P PEs.
// Each advance processes chunk `chunk` (words chunk*P .. chunk*P+P-1) against
// the multiplier word `mul`. Sums shift down one word; carries stay in place.
// The top accumulator is only ever cleared. Assumes L is a multiple of P.
module mm_mac_lane #(
    parameter int W = 16,
    parameter int L = 4,
    parameter int P = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                advance,
    input  logic [((L/P)>1 ? $clog2(L/P) : 1)-1:0] chunk,
    input  logic [W-1:0]        mul,
    input  logic [P-1:0][W-1:0] mcand,
    output logic [W-1:0]        low_sum
);
    localparam int K  = L / P;
    localparam int IW = (L > 1) ? $clog2(L) : 1;
    localparam int KW = (K > 1) ? $clog2(K) : 1;

    logic [W-1:0] acc [L];
    logic [W-1:0] cry [L];
    logic [P-1:0][W-1:0] t_in, c_in, s_out, c_out;

    function automatic logic [IW-1:0] widx(input logic [KW-1:0] k, input int e);
        return IW'(int'(k) * P + e);
    endfunction

    function automatic logic [IW-1:0] wprev(input logic [KW-1:0] k, input int e);
        return IW'(int'(k) * P + e - 1);
    endfunction

    // Fetch the accumulator and carry words of the current chunk
    always_comb begin
        for (int e = 0; e < P; e++) begin
            t_in[e] = acc[widx(chunk, e)];
            c_in[e] = cry[widx(chunk, e)];
        end
    end

    for (genvar e = 0; e < P; e++) begin : g_pe
        mm_pe #(.W(W)) u_pe (
            .a    (mul),
            .b    (mcand[e]),
            .t    (t_in[e]),
            .c    (c_in[e]),
            .sum  (s_out[e]),
            .carry(c_out[e])
        );
    end

    // Clear on start, otherwise shift sums down and keep carries per element
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            for (int j = 0; j < L; j++) begin
                acc[j] <= '0;
                cry[j] <= '0;
            end
        end else if (advance) begin
            for (int e = 0; e < P; e++) begin
                cry[widx(chunk, e)] <= c_out[e];
                if (int'(chunk) * P + e > 0)
                    acc[wprev(chunk, e)] <= s_out[e];
            end
        end
    end

    assign low_sum = s_out[0];
endmodule

// File: rtl/mm_addsub.sv
// Word adder and subtractor run back to back: s = x + y + cin and
// d = s - sub - bin, with a one-bit carry out and a one-bit borrow out.
module mm_addsub #(
    parameter int W = 16
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    input  logic [W-1:0] sub,
    input  logic         bin,
    output logic [W-1:0] s,
    output logic         cout,
    output logic [W-1:0] d,
    output logic         bout
);
    logic [W:0] sx, dx;

    // Add with carry, then subtract the sum's low word with borrow
    always_comb begin
        sx   = {1'b0, x} + {1'b0, y} + (W+1)'(cin);
        s    = sx[W-1:0];
        cout = sx[W];
        dx   = {1'b0, sx[W-1:0]} - {1'b0, sub} - (W+1)'(bin);
        d    = dx[W-1:0];
        bout = dx[W];
    end
endmodule

// File: rtl/mm_montmul.sv
// Montgomery multiplier top: R = A*B*2^(-W*L) mod N in one pass of 2*L
// outer steps, each taking L/P cycles. Chunk 0 of each step chains the lowest
// word of the A*B lane into the Q lane, then into the Q*N lane, then into the
// adder/subtractor. Later chunks reuse the registered lane multiplier words.
// Assumes: N odd, A,B < N, coefficient = -N^-1 mod 2^(W*L), L a multiple of P,
// and no operand writes while busy.
module mm_montmul
    import mm_pkg::*;
#(
    parameter int W = 16,
    parameter int L = 4,
    parameter int P = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [1:0]                       wr_sel,
    input  logic [((L>1) ? $clog2(L) : 1)-1:0] wr_addr,
    input  logic [W-1:0]                     wr_data,
    input  logic                             start,
    output logic                             busy,
    output logic                             done,
    input  logic [((L>1) ? $clog2(L) : 1)-1:0] rd_addr,
    output logic [W-1:0]                     rd_data
);
    localparam int K  = L / P;
    localparam int IW = (L > 1) ? $clog2(L) : 1;
    localparam int KW = (K > 1) ? $clog2(K) : 1;
    localparam int SW = $clog2(2 * L) + 1;

    logic [W-1:0]  opm    [4][L];
    logic [W-1:0]  s_mem  [L];
    logic [W-1:0]  sn_mem [L];

    mm_state_t     state;
    logic [SW-1:0] step;
    logic [KW-1:0] chunk;
    logic          carry_q, borrow_q, sel_q, done_q;
    logic [W-1:0]  qmul_q, qnmul_q;

    logic          run, first, lo_half, last_chunk, last_step, accept;
    logic [IW-1:0] hidx;
    logic [W-1:0]  mul_ab, mul_q, mul_qn, low_ab, low_q, low_qn, sub_w;
    logic [W-1:0]  s_w, d_w;
    logic          cout_w, bout_w;
    logic [P-1:0][W-1:0] mc_b, mc_nc, mc_n;

    // Operand memories, one write port
    always_ff @(posedge clk) begin
        if (wr_en)
            opm[wr_sel][wr_addr] <= wr_data;
    end

    // Step decode and lane multiplier selection
    always_comb begin
        run        = (state == ST_RUN);
        accept     = (state == ST_IDLE) && start;
        first      = (chunk == '0);
        lo_half    = (step < SW'(L));
        last_chunk = (chunk == KW'(K - 1));
        last_step  = (step == SW'(2 * L - 1));
        hidx       = IW'(step - SW'(L));
        mul_ab     = lo_half ? opm[OP_A][step[IW-1:0]] : '0;
        mul_q      = first ? (lo_half ? low_ab : '0) : qmul_q;
        mul_qn     = first ? (lo_half ? low_q  : '0) : qnmul_q;
        sub_w      = lo_half ? '0 : opm[OP_N][hidx];
    end

    // Multiplicand words of the current chunk for each lane
    always_comb begin
        for (int e = 0; e < P; e++) begin
            mc_b[e]  = opm[OP_B] [IW'(int'(chunk) * P + e)];
            mc_nc[e] = opm[OP_NC][IW'(int'(chunk) * P + e)];
            mc_n[e]  = opm[OP_N] [IW'(int'(chunk) * P + e)];
        end
    end

    mm_mac_lane #(.W(W), .L(L), .P(P)) u_lane_ab (
        .clk(clk), .rst_n(rst_n), .clear(accept), .advance(run),
        .chunk(chunk), .mul(mul_ab), .mcand(mc_b), .low_sum(low_ab)
    );

    mm_mac_lane #(.W(W), .L(L), .P(P)) u_lane_q (
        .clk(clk), .rst_n(rst_n), .clear(accept), .advance(run),
        .chunk(chunk), .mul(mul_q), .mcand(mc_nc), .low_sum(low_q)
    );

    mm_mac_lane #(.W(W), .L(L), .P(P)) u_lane_qn (
        .clk(clk), .rst_n(rst_n), .clear(accept), .advance(run),
        .chunk(chunk), .mul(mul_qn), .mcand(mc_n), .low_sum(low_qn)
    );

    mm_addsub #(.W(W)) u_addsub (
        .x(low_ab), .y(low_qn), .cin(carry_q), .sub(sub_w), .bin(borrow_q),
        .s(s_w), .cout(cout_w), .d(d_w), .bout(bout_w)
    );

    // Capture both candidate high words during the upper half of the pass
    always_ff @(posedge clk) begin
        if (run && first && !lo_half) begin
            s_mem[hidx]  <= s_w;
            sn_mem[hidx] <= d_w;
        end
    end

    // Controller: step/chunk sequencing, chain registers and result select
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            step     <= '0;
            chunk    <= '0;
            carry_q  <= 1'b0;
            borrow_q <= 1'b0;
            qmul_q   <= '0;
            qnmul_q  <= '0;
            sel_q    <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state    <= ST_RUN;
                        step     <= '0;
                        chunk    <= '0;
                        carry_q  <= 1'b0;
                        borrow_q <= 1'b0;
                    end
                end
                ST_RUN: begin
                    if (first) begin
                        qmul_q   <= mul_q;
                        qnmul_q  <= mul_qn;
                        carry_q  <= cout_w;
                        borrow_q <= bout_w;
                    end
                    if (last_chunk) begin
                        chunk <= '0;
                        if (last_step) state <= ST_FIN;
                        else           step  <= step + 1'b1;
                    end else begin
                        chunk <= chunk + 1'b1;
                    end
                end
                ST_FIN: begin
                    sel_q  <= borrow_q & ~carry_q;
                    done_q <= 1'b1;
                    state  <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy    = (state != ST_IDLE);
    assign done    = done_q;
    assign rd_data = sel_q ? s_mem[rd_addr] : sn_mem[rd_addr];
endmodule

// File: rtl/mm_montmul_chk.sv
// Protocol checker for mm_montmul: handshake, latency window and result
// stability. Counts busy cycles itself so no long $past window is needed.
module mm_montmul_chk #(
    parameter int W = 16,
    parameter int L = 4,
    parameter int P = 2
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             start,
    input logic                             busy,
    input logic                             done,
    input logic [((L>1) ? $clog2(L) : 1)-1:0] rd_addr,
    input logic [W-1:0]                     rd_data
);
    localparam int LAT = 2 * L * (L / P) + 1;

    logic [31:0] cnt;
    logic        live;

    // Busy-cycle counter and a flag marking one cycle past reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            live <= 1'b0;
        end else begin
            live <= 1'b1;
            cnt  <= busy ? cnt + 1 : '0;
        end
    end

    // R3
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && cnt == LAT));

    // R5
    busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt < LAT));

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !busy && !$past(busy) && $stable(rd_addr)) |-> $stable(rd_data));
endmodule

bind mm_montmul mm_montmul_chk #(.W(W), .L(L), .P(P)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/mm_montmul_bench.sv
`timescale 1ns/1ps
module mm_montmul_bench;
    localparam int W  = 16;
    localparam int L  = 4;
    localparam int P  = 2;
    localparam int NB = W * L;
    localparam int IW = (L > 1) ? $clog2(L) : 1;
    localparam int EXP_LAT = 2 * L * (L / P) + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_sel = '0;
    logic [IW-1:0] wr_addr = '0;
    logic [W-1:0]  wr_data = '0;
    logic          start = 1'b0;
    logic          busy, done;
    logic [IW-1:0] rd_addr = '0;
    logic [W-1:0]  rd_data;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    mm_montmul #(.W(W), .L(L), .P(P)) u_mm_montmul (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_addr(wr_addr), .wr_data(wr_data), .start(start), .busy(busy),
        .done(done), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // Reference: bit-serial reduction of the full product
    function automatic logic [NB-1:0] mont_ref(input logic [NB-1:0] a, b, n);
        logic [2*NB+1:0] x;
        x = (2*NB+2)'(a) * (2*NB+2)'(b);
        for (int k = 0; k < NB; k++) begin
            if (x[0]) x = x + (2*NB+2)'(n);
            x = x >> 1;
        end
        if (x >= (2*NB+2)'(n)) x = x - (2*NB+2)'(n);
        return x[NB-1:0];
    endfunction

    // Coefficient -N^-1 mod 2^NB by Newton iteration
    function automatic logic [NB-1:0] coeff(input logic [NB-1:0] n);
        logic [NB-1:0] v;
        v = n;
        for (int k = 0; k < 7; k++) v = v * (NB'(2) - n * v);
        return -v;
    endfunction

    function automatic logic [NB-1:0] rnd64();
        return {$urandom, $urandom};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [NB-1:0] act, input logic [NB-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic load(input logic [1:0] sel, input logic [NB-1:0] v);
        for (int w = 0; w < L; w++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_sel = sel; wr_addr = IW'(w); wr_data = v[w*W +: W];
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_res(output logic [NB-1:0] r);
        for (int w = 0; w < L; w++) begin
            @(negedge clk);
            rd_addr = IW'(w);
            #1 r[w*W +: W] = rd_data;
        end
    endtask

    // Load operands, launch, wait for done; optionally inject start mid-run
    task automatic run_mul(input logic [NB-1:0] a, b, n, input bit poke,
                           output logic [NB-1:0] r, output int lat);
        load(2'd0, a);
        load(2'd1, b);
        load(2'd2, coeff(n));
        load(2'd3, n);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 1000) begin
            start = (poke && lat == 3);
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        if (!done) begin
            tests++; fails++;
            $display("FAIL R4 watchdog: actual %0d cycles expected %0d", lat, EXP_LAT);
        end
        read_res(r);
    endtask

    task automatic case_check(input string tag, input logic [NB-1:0] a, b, n);
        logic [NB-1:0] r;
        int lat;
        run_mul(a, b, n, 1'b0, r, lat);
        chk("R1", tag, r, mont_ref(a, b, n));
        chk("R7", {tag, " below N"}, NB'(r < n), NB'(1));
        chk("R4", {tag, " latency"}, NB'(lat), NB'(EXP_LAT));
    endtask

    initial begin
        #(200000 * 20);
        fails++; tests++;
        $display("FAIL R4 global watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [NB-1:0] n, a, b, r, r2;
        int lat;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R3 reset state
        chk("R3", "busy after reset", NB'(busy), NB'(0));
        chk("R3", "done after reset", NB'(done), NB'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk("R3", "idle after reset release", NB'(busy), NB'(0));

        // R1 directed: zero and unit operands
        n = rnd64() | NB'(1);
        case_check("zero A", '0, rnd64() % n, n);
        case_check("unit A,B", NB'(1), NB'(1), n);

        // R7 overflow path: all-ones modulus
        n = '1;
        case_check("max N", n - 1, n - 1, n);
        n = {1'b1, {(NB-2){1'b0}}, 1'b1};
        case_check("top-bit N", n - 1, n - 2, n);

        // R1 random odd moduli, full and reduced width
        for (int k = 0; k < 20; k++) begin
            n = rnd64() | NB'(1);
            if (k % 4 == 0) n[NB-1] = 1'b1;
            if (k % 5 == 1) n = n >> 20 | NB'(1);
            a = rnd64() % n;
            b = rnd64() % n;
            case_check("random", a, b, n);
        end

        // R5 start pulse mid-run is ignored
        n = rnd64() | NB'(1);
        a = rnd64() % n;
        b = rnd64() % n;
        run_mul(a, b, n, 1'b1, r, lat);
        chk("R5", "result with stray start", r, mont_ref(a, b, n));
        chk("R5", "latency with stray start", NB'(lat), NB'(EXP_LAT));

        // R6 no residue: repeat after a different operation
        run_mul(a, b, n, 1'b0, r, lat);
        run_mul(n - 1, n - 1, n, 1'b0, r2, lat);
        run_mul(a, b, n, 1'b0, r2, lat);
        chk("R6", "repeat after other operands", r2, r);

        // R8 result held across idle cycles and operand writes
        load(2'd0, rnd64());
        load(2'd3, rnd64() | NB'(1));
        repeat (5) @(negedge clk);
        read_res(r);
        chk("R8", "result held while idle", r, r2);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule